// File: doc/BRIEF.md
# Configuration Startup Sequencer

This block is the control logic on the receiving side of a configuration load. Once the active-low reconfigure input is seen high, it accepts a fixed number of configuration frames. It then runs an initialization phase clocked by a selectable tick. In that phase it releases the register clear and the I/O output enable one after the other, in an order chosen by a mode bit. At the end it enters user mode. In user mode it can apply an optional global clear and an optional global output disable.

When a configuration error is flagged, the block pulls the open-drain status line low for a fixed time-out and then lets it go. Its next step depends on the restart policy. With automatic restart, it starts loading again as soon as it sees the shared status line high. With manual restart, it waits for a low-then-high pulse on the reconfigure input. The open-drain init-done flag is pulled low only after the first frame arrives and only when that option is enabled. The flag is let go when user mode begins.

Top module: `cfg_startup_seq`

## Requirements
- R1: After reset, status_low=0, done_low=0, reg_clr=1 and io_en=0. The block stays idle, accepting no frames, until the synchronized reconf_n reads high.
- R2: A cfg_err pulse while loading sets status_low=1 for exactly RST_TIMEOUT clock cycles (default 16). During that time done_low=0, and reconf_n has no effect.
- R3: With auto_restart=0, after the time-out the block ignores frame_rx until reconf_n goes low and then high again. After that it loads normally.
- R4: With auto_restart=1, after the time-out the block ignores frame_rx while status_pad reads low. Once status_pad reads high, it resumes loading with no reconfigure pulse.
- R5: While loading, while in error and while waiting to restart, io_en=0 and reg_clr=1.
- R6: With clr_first=1, reg_clr falls after INIT_CYCLES/2 init ticks while io_en is still 0. io_en rises INIT_CYCLES/2 ticks later.
- R7: With clr_first=0, io_en rises after INIT_CYCLES/2 init ticks while reg_clr is still 1. reg_clr falls INIT_CYCLES/2 ticks later.
- R8: done_low is 0 before the first frame. It becomes 1 on the first frame only when initdone_en=1, and it returns to 0 on entry to user mode, on an error or on a reconfigure.
- R9: The initialization counts int_osc_en when init_clk_sel=0 and user_clk_en when init_clk_sel=1. Ticks on the unselected input are ignored.
- R10: In user mode with goe_en=1, goe_n=0 gives io_en=0 and goe_n=1 gives io_en=1. With goe_en=0, goe_n is ignored.
- R11: In user mode with gclr_en=1, gclr_n=0 gives reg_clr=1. With gclr_en=0, gclr_n is ignored and reg_clr=0.
- R12: reconf_n low in user mode returns the block to its idle outputs: io_en=0, reg_clr=1, done_low=0.
- R13: Loading ends only on the NUM_FRAMES-th frame_rx pulse (default 4). After fewer frames, no release takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reconf_n | input | 1 | Active-low reconfigure request, asynchronous |
| cfg_err | input | 1 | Configuration error detected, one-cycle pulse |
| frame_rx | input | 1 | One configuration frame received, one-cycle pulse |
| int_osc_en | input | 1 | Internal oscillator tick enable |
| user_clk_en | input | 1 | External user clock tick enable |
| status_pad | input | 1 | Level read back from the shared status line, asynchronous |
| gclr_n | input | 1 | Global clear, active low, asynchronous |
| goe_n | input | 1 | Global output enable, active low, asynchronous |
| auto_restart | input | 1 | 1: restart on its own after an error |
| clr_first | input | 1 | 1: release the clear before the outputs |
| init_clk_sel | input | 1 | 0: internal tick, 1: user tick |
| initdone_en | input | 1 | Enable the init-done flag |
| gclr_en | input | 1 | Enable the global clear input |
| goe_en | input | 1 | Enable the global output enable input |
| status_low | output | 1 | Drive the open-drain status line low |
| done_low | output | 1 | Drive the open-drain init-done line low |
| reg_clr | output | 1 | Clear to all user registers |
| io_en | output | 1 | Output enable to all user I/O |

## Verification
The hardest situation to reach is the automatic restart while another device on the shared status line keeps it low after this block has let go. The bench models that line as the wired-AND of the block's own drive and an extra external hold. It keeps the hold active through the time-out and beyond, sends frames that must be ignored, and only then releases the hold and loads without any reconfigure pulse. The manual policy is covered in a similar way: frames sent after the time-out must change nothing until a full reconfigure pulse has been applied.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CONFIG = 3'd1,
    ST_ERR    = 3'd2,
    ST_WAIT   = 3'd3,
    ST_INIT   = 3'd4,
    ST_USER   = 3'd5
  } seq_state_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cfg_cnt.sv
module cfg_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt
);
  always_comb begin
    if (clr)      cnt_nxt = '0;
    else if (inc) cnt_nxt = cnt_q + 1'b1;
    else          cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
  import cfg_seq_pkg::*;
#(
  parameter int NUM_FRAMES  = 4,
  parameter int RST_TIMEOUT = 16,
  parameter int INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic reconf_n,
  input  logic cfg_err,
  input  logic frame_rx,
  input  logic int_osc_en,
  input  logic user_clk_en,
  input  logic status_pad,
  input  logic gclr_n,
  input  logic goe_n,
  input  logic auto_restart,
  input  logic clr_first,
  input  logic init_clk_sel,
  input  logic initdone_en,
  input  logic gclr_en,
  input  logic goe_en,
  output logic status_low,
  output logic done_low,
  output logic reg_clr,
  output logic io_en
);
  localparam int STAGE = INIT_CYCLES / 2;
  localparam int MAX_A = (NUM_FRAMES > RST_TIMEOUT) ? NUM_FRAMES : RST_TIMEOUT;
  localparam int MAXC  = (MAX_A > INIT_CYCLES) ? MAX_A : INIT_CYCLES;
  localparam int CW    = $clog2(MAXC + 1);

  logic [3:0] sync_q;
  logic reconf_s, gclr_s, goe_s, pad_s;

  cfg_sync #(.W(4), .RST_VAL(4'b0111)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({reconf_n, gclr_n, goe_n, status_pad}),
    .q   (sync_q)
  );
  assign {reconf_s, gclr_s, goe_s, pad_s} = sync_q;

  seq_state_t state_q, state_d;
  logic armed_q, armed_d;
  logic cnt_clr, cnt_inc;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic tick;

  cfg_cnt #(.W(CW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (cnt_clr),
    .inc     (cnt_inc),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  assign tick = init_clk_sel ? user_clk_en : int_osc_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        armed_d = 1'b0;
        cnt_clr = 1'b1;
        if (reconf_s) state_d = ST_CONFIG;
      end
      ST_CONFIG: begin
        if (cfg_err) begin
          state_d = ST_ERR;
          armed_d = 1'b0;
          cnt_clr = 1'b1;
        end else if (frame_rx) begin
          cnt_inc = 1'b1;
          if (cnt_q == '0 && initdone_en) armed_d = 1'b1;
          if (cnt_q == CW'(NUM_FRAMES - 1)) begin
            state_d = ST_INIT;
            cnt_clr = 1'b1;
          end
        end
      end
      ST_ERR: begin
        cnt_inc = 1'b1;
        if (cnt_q == CW'(RST_TIMEOUT - 1)) begin
          state_d = ST_WAIT;
          cnt_clr = 1'b1;
        end
      end
      ST_WAIT: begin
        if (auto_restart && pad_s) begin
          state_d = ST_CONFIG;
          cnt_clr = 1'b1;
        end
      end
      ST_INIT: begin
        if (tick) begin
          cnt_inc = 1'b1;
          if (cnt_q == CW'(INIT_CYCLES - 1)) begin
            state_d = ST_USER;
            cnt_clr = 1'b1;
          end
        end
      end
      ST_USER: ;
      default: state_d = ST_IDLE;
    endcase
    // a reconfigure request aborts everything except the error hold
    if (!reconf_s && state_q != ST_ERR && state_q != ST_IDLE) begin
      state_d = ST_IDLE;
      armed_d = 1'b0;
      cnt_clr = 1'b1;
    end
  end

  // outputs are registered from the next-state values
  logic early_rel, clr_d, ioen_d;

  always_comb begin
    early_rel = (state_d == ST_INIT) && (cnt_nxt >= CW'(STAGE));
    clr_d  = 1'b1;
    ioen_d = 1'b0;
    if (state_d == ST_USER) begin
      clr_d  = gclr_en & ~gclr_s;
      ioen_d = ~(goe_en & ~goe_s);
    end else if (state_d == ST_INIT) begin
      clr_d  = clr_first ? ~early_rel : 1'b1;
      ioen_d = clr_first ? 1'b0 : early_rel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      armed_q    <= 1'b0;
      status_low <= 1'b0;
      done_low   <= 1'b0;
      reg_clr    <= 1'b1;
      io_en      <= 1'b0;
    end else begin
      state_q    <= state_d;
      armed_q    <= armed_d;
      status_low <= (state_d == ST_ERR);
      done_low   <= armed_d && (state_d != ST_USER);
      reg_clr    <= clr_d;
      io_en      <= ioen_d;
    end
  end
endmodule

// File: rtl/cfg_startup_seq_chk.sv
module cfg_startup_seq_chk #(
  parameter int RST_TIMEOUT = 16
) (
  input logic clk,
  input logic rst,
  input logic clr_first,
  input logic gclr_en,
  input logic goe_en,
  input logic status_low,
  input logic done_low,
  input logic reg_clr,
  input logic io_en
);
  int hold_cnt;

  always_ff @(posedge clk) begin
    if (rst)             hold_cnt <= 0;
    else if (status_low) hold_cnt <= hold_cnt + 1;
    else                 hold_cnt <= 0;
  end

  AST_ERR_IO_OFF: assert property (@(posedge clk) disable iff (rst)
    status_low |-> (!io_en && reg_clr)); // R5

  AST_HOLD_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(status_low) |-> (hold_cnt == RST_TIMEOUT)); // R2

  AST_CLR_BEFORE_IO: assert property (@(posedge clk) disable iff (rst)
    ($rose(io_en) && clr_first && !gclr_en) |-> !reg_clr); // R6

  AST_IO_BEFORE_CLR: assert property (@(posedge clk) disable iff (rst)
    ($fell(reg_clr) && !clr_first && !goe_en) |-> io_en); // R7

  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    status_low |-> !done_low); // R8
endmodule

bind cfg_startup_seq cfg_startup_seq_chk #(.RST_TIMEOUT(RST_TIMEOUT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_first  (clr_first),
  .gclr_en    (gclr_en),
  .goe_en     (goe_en),
  .status_low (status_low),
  .done_low   (done_low),
  .reg_clr    (reg_clr),
  .io_en      (io_en)
);

// File: tb/cfg_startup_seq_tb.sv
module cfg_startup_seq_tb;
  localparam int NF = 4, RT = 16, IC = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic reconf_n = 1'b0, cfg_err = 1'b0, frame_rx = 1'b0;
  logic int_osc_en = 1'b1, user_clk_en = 1'b0, ext_hold = 1'b0;
  logic gclr_n = 1'b1, goe_n = 1'b1;
  logic auto_restart = 1'b0, clr_first = 1'b1, init_clk_sel = 1'b0;
  logic initdone_en = 1'b1, gclr_en = 1'b0, goe_en = 1'b0;
  logic status_low, done_low, reg_clr, io_en, status_pad;

  assign status_pad = ~(status_low | ext_hold);

  always #10 clk = ~clk;

  cfg_startup_seq #(.NUM_FRAMES(NF), .RST_TIMEOUT(RT), .INIT_CYCLES(IC)) u_dut (
    .clk(clk), .rst(rst), .reconf_n(reconf_n), .cfg_err(cfg_err), .frame_rx(frame_rx),
    .int_osc_en(int_osc_en), .user_clk_en(user_clk_en), .status_pad(status_pad),
    .gclr_n(gclr_n), .goe_n(goe_n), .auto_restart(auto_restart), .clr_first(clr_first),
    .init_clk_sel(init_clk_sel), .initdone_en(initdone_en), .gclr_en(gclr_en),
    .goe_en(goe_en), .status_low(status_low), .done_low(done_low), .reg_clr(reg_clr),
    .io_en(io_en)
  );

  // scoreboard: vector order {status_low, done_low, reg_clr, io_en}
  typedef struct {
    string      req;
    logic [3:0] mask;
    logic [3:0] act;
    logic [3:0] exp;
  } item_t;

  item_t sb_q[$];
  int n_vec = 0, n_bad = 0;
  bit done_flag = 1'b0;

  task automatic expect_out(input string req, input logic [3:0] mask, input logic [3:0] exp);
    item_t it;
    it.req  = req;
    it.mask = mask;
    it.act  = {status_low, done_low, reg_clr, io_en};
    it.exp  = exp;
    sb_q.push_back(it);
  endtask

  task automatic expect_int(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      n_vec++;
      if ((it.act & it.mask) !== (it.exp & it.mask)) begin
        n_bad++;
        $display("FAIL %s: actual %b expected %b (mask %b)", it.req, it.act, it.exp, it.mask);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame();
    frame_rx = 1'b1;
    @(negedge clk);
    frame_rx = 1'b0;
    @(negedge clk);
  endtask

  task automatic reconf_pulse();
    reconf_n = 1'b0;
    cyc(6);
    reconf_n = 1'b1;
    cyc(6);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      #1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : driver
    int n;
    cyc(3);
    rst = 1'b0;
    cyc(8);
    // R1: reset and idle outputs, frames ignored while reconf_n low
    expect_out("R1 reset", 4'b1111, 4'b0010);
    for (int i = 0; i < NF; i++) send_frame();
    cyc(20);
    expect_out("R1 idle ignores frames", 4'b1111, 4'b0010);

    // normal load, clear released first, init-done enabled
    reconf_n = 1'b1;
    cyc(6);
    expect_out("R8 no done before frame", 4'b0100, 4'b0000);
    send_frame();
    expect_out("R8 done after first frame", 4'b0100, 4'b0100);
    send_frame();
    send_frame();
    cyc(20);
    expect_out("R13 short of frames", 4'b0011, 4'b0010);
    send_frame();
    n = 0;
    while (reg_clr && n < 50) begin n++; cyc(1); end
    expect_out("R6 clear released, io still off", 4'b0111, 4'b0100);
    n = 0;
    while (!io_en && n < 50) begin n++; cyc(1); end
    expect_int("R6 ticks between releases", n, IC / 2);
    expect_out("R8 done released in user", 4'b0111, 4'b0001);

    // user mode globals
    goe_en = 1'b1; goe_n = 1'b0; cyc(5);
    expect_out("R10 goe low disables io", 4'b0001, 4'b0000);
    goe_n = 1'b1; cyc(5);
    expect_out("R10 goe high enables io", 4'b0001, 4'b0001);
    goe_en = 1'b0; goe_n = 1'b0; cyc(5);
    expect_out("R10 goe ignored when off", 4'b0001, 4'b0001);
    goe_n = 1'b1;
    gclr_n = 1'b0; cyc(5);
    expect_out("R11 gclr ignored when off", 4'b0010, 4'b0000);
    gclr_en = 1'b1; cyc(5);
    expect_out("R11 gclr clears", 4'b0010, 4'b0010);
    gclr_n = 1'b1; cyc(5);
    expect_out("R11 gclr released", 4'b0010, 4'b0000);
    gclr_en = 1'b0;

    // manual restart after error, io released first, init-done disabled
    reconf_n = 1'b0; cyc(6);
    expect_out("R12 reconfigure from user", 4'b1111, 4'b0010);
    auto_restart = 1'b0; clr_first = 1'b0; initdone_en = 1'b0;
    reconf_n = 1'b1; cyc(6);
    send_frame();
    expect_out("R8 no done when disabled", 4'b0100, 4'b0000);
    cfg_err = 1'b1; cyc(1); cfg_err = 1'b0;
    expect_out("R5 error outputs", 4'b1111, 4'b1010);
    n = 0;
    while (status_low && n < 100) begin n++; cyc(1); end
    expect_int("R2 hold length", n, RT);
    cyc(10);
    for (int i = 0; i < NF; i++) send_frame();
    cyc(20);
    expect_out("R3 frames ignored without pulse", 4'b1111, 4'b0010);
    reconf_pulse();
    for (int i = 0; i < NF; i++) send_frame();
    n = 0;
    while (!io_en && n < 50) begin n++; cyc(1); end
    expect_out("R7 io released, clear held", 4'b0011, 4'b0011);
    n = 0;
    while (reg_clr && n < 50) begin n++; cyc(1); end
    expect_int("R7 ticks between releases", n, IC / 2);
    expect_out("R3 loaded after pulse", 4'b0011, 4'b0001);

    // automatic restart while the shared line is held low
    reconf_n = 1'b0; cyc(6);
    auto_restart = 1'b1; clr_first = 1'b1; initdone_en = 1'b1;
    reconf_n = 1'b1; cyc(6);
    send_frame();
    ext_hold = 1'b1;
    cfg_err = 1'b1; cyc(1); cfg_err = 1'b0;
    expect_out("R2 error drops done", 4'b1100, 4'b1000);
    cyc(RT + 10);
    for (int i = 0; i < NF; i++) send_frame();
    cyc(20);
    expect_out("R4 waits while line low", 4'b1011, 4'b0010);
    ext_hold = 1'b0;
    cyc(6);
    for (int i = 0; i < NF; i++) send_frame();
    n = 0;
    while (!io_en && n < 60) begin n++; cyc(1); end
    expect_out("R4 restarted without pulse", 4'b0011, 4'b0001);

    // external init clock
    reconf_n = 1'b0; cyc(6);
    clr_first = 1'b0; init_clk_sel = 1'b1;
    reconf_n = 1'b1; cyc(6);
    for (int i = 0; i < NF; i++) send_frame();
    cyc(40);
    expect_out("R9 internal ticks ignored", 4'b0011, 4'b0010);
    for (int i = 0; i < IC / 2; i++) begin
      user_clk_en = 1'b1; cyc(1); user_clk_en = 1'b0; cyc(2);
    end
    cyc(2);
    expect_out("R9 half of user ticks", 4'b0011, 4'b0011);
    for (int i = 0; i < IC / 2; i++) begin
      user_clk_en = 1'b1; cyc(1); user_clk_en = 1'b0; cyc(2);
    end
    cyc(2);
    expect_out("R9 all user ticks", 4'b0011, 4'b0001);
    reconf_n = 1'b0; cyc(6);
    expect_out("R12 back to idle", 4'b1111, 4'b0010);

    cyc(2);
    wait (sb_q.size() == 0);
    finish_run();
  end
endmodule